// File: doc/BRIEF.md
# Pseudo-Random Program Counter Fault Injector

This block is a test harness that stands in for a processor's program counter and damages it on purpose at unpredictable moments. While enabled it steps the counter by one each cycle. On cycles picked by a pseudo-noise sequence, it instead loads the counter with a value taken from a second, independent pseudo-noise sequence. A watchdog under test watches the counter and raises its detect line when it notices the disturbance. The harness counts how many injected faults were caught in this way.

The two pseudo-noise sources are maximal-length Fibonacci shift registers. Their width, feedback taps and reset seeds are parameters. The injection rate comes from a mask parameter: a fault is injected whenever every bit of the pulse register selected by the mask is one. The watchdog itself is outside this block.

Top module: `pc_fault_injector`

## Requirements
- R1: While `rst_n` is low, `pc_out` is 0, `catch_count` is 0, and both pseudo-noise registers hold their seed parameters.
- R2: While `run_en` is low, `pc_out` and both pseudo-noise registers hold their values, and `inject_strobe` stays low.
- R3: In an enabled cycle with `inject_strobe` low, `pc_out` becomes `pc_out + 1` modulo 2^PC_W on the next clock edge.
- R4: `inject_strobe` is high in exactly those enabled cycles where `(pulse register & TRIG_MASK) == TRIG_MASK`.
- R5: In a cycle with `inject_strobe` high, `pc_out` is loaded on the next edge with the low PC_W bits of the data register.
- R6: In each enabled cycle, each pseudo-noise register `s` steps to `{s[PN_W-2:0], ^(s & PN_TAPS)}`, so bit 0 takes the XOR of the tapped bits.
- R7: A rising edge of `wd_detect` (high now, low in the previous cycle) adds one to `catch_count` on the next edge, but only if an injection happened in an earlier cycle and has not yet been credited. Each injection is credited at most once, and several uncredited injections count as one.
- R8: A rising edge of `wd_detect` with no uncredited injection pending does not change `catch_count`, and neither does `wd_detect` staying high.
- R9: `catch_count` saturates at 2^CNT_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Advances the counter and both noise registers |
| wd_detect | input | 1 | Detect line from the watchdog under test |
| pc_out | output | PC_W | Modelled program counter |
| inject_strobe | output | 1 | High in a cycle whose update is a fault load |
| catch_count | output | CNT_W | Number of credited detections, saturating |

## Verification
The bench builds the block with 8-bit noise registers using taps 8'hB8, seeds 8'h5A and 8'hC3, PC_W of 8, a two-bit trigger mask of 8'h03 and a 3-bit count. The narrow mask makes about one cycle in four an injection, so injections, back-to-back loads and uncredited detect edges all occur within a few hundred cycles. The 3-bit count reaches saturation in the same run. An 8-bit counter also makes incrementer wrap-around reachable.

// File: rtl/pc_fault_injector.sv
module pc_fault_injector #(
  parameter int PC_W = 16,
  parameter int PN_W = 16,
  parameter logic [PN_W-1:0] PN_TAPS    = 16'hB400,
  parameter logic [PN_W-1:0] DATA_SEED  = 16'hACE1,
  parameter logic [PN_W-1:0] PULSE_SEED = 16'h1D0F,
  parameter logic [PN_W-1:0] TRIG_MASK  = 16'h00F0,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             wd_detect,
  output logic [PC_W-1:0]  pc_out,
  output logic             inject_strobe,
  output logic [CNT_W-1:0] catch_count
);

  logic [PN_W-1:0]  data_pn, pulse_pn;
  logic [PC_W-1:0]  pc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q, det_q;
  logic             fire, det_rise, credit;

  function automatic logic [PN_W-1:0] pn_step(input logic [PN_W-1:0] s);
    return {s[PN_W-2:0], ^(s & PN_TAPS)};
  endfunction

  assign fire     = run_en && ((pulse_pn & TRIG_MASK) == TRIG_MASK);
  assign det_rise = wd_detect && !det_q;
  assign credit   = det_rise && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_pn  <= DATA_SEED;
      pulse_pn <= PULSE_SEED;
      pc_q     <= '0;
    end else if (run_en) begin
      data_pn  <= pn_step(data_pn);
      pulse_pn <= pn_step(pulse_pn);
      pc_q     <= fire ? data_pn[PC_W-1:0] : pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      det_q   <= wd_detect;
      armed_q <= fire || (armed_q && !det_rise);
      if (credit && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pc_out        = pc_q;
  assign inject_strobe = fire;
  assign catch_count   = cnt_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(pc_out)); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !inject_strobe) |=> pc_out == PC_W'($past(pc_out) + 1'b1)); // R3
  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    inject_strobe |=> pc_out == $past(data_pn[PC_W-1:0])); // R5
  AST_PN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    data_pn != '0 && pulse_pn != '0); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    catch_count == $past(catch_count) ||
    catch_count == CNT_W'($past(catch_count) + 1'b1)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (&catch_count) |=> (&catch_count)); // R9

endmodule

// File: tb/pc_fault_injector_tb_top.sv
module pc_fault_injector_tb_top;
  localparam int PC_W = 8, PN_W = 8, CNT_W = 3;
  localparam logic [7:0] TAPS = 8'hB8, DSEED = 8'h5A, PSEED = 8'hC3, MASK = 8'h03;

  logic clk = 0, rst_n = 0, run_en = 0, wd_detect = 0;
  logic [PC_W-1:0] pc_out;
  logic inject_strobe;
  logic [CNT_W-1:0] catch_count;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pc_fault_injector #(.PC_W(PC_W), .PN_W(PN_W), .PN_TAPS(TAPS), .DATA_SEED(DSEED),
    .PULSE_SEED(PSEED), .TRIG_MASK(MASK), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wd_detect(wd_detect),
    .pc_out(pc_out), .inject_strobe(inject_strobe), .catch_count(catch_count));

  typedef struct {
    logic [PC_W-1:0] pc;
    logic stb;
    logic [CNT_W-1:0] cnt;
    string tag;
  } item_t;
  item_t sb_q[$];

  logic [7:0] m_dl = DSEED, m_pl = PSEED, m_pc = 0;
  logic m_armed = 0, m_prev = 0;
  logic [CNT_W-1:0] m_cnt = 0;
  string m_tag = "R1";

  function automatic logic [7:0] pn(input logic [7:0] s);
    return {s[6:0], ^(s & TAPS)};
  endfunction

  task automatic step(input logic en, input logic det);
    item_t it;
    logic f, rise;
    @(negedge clk);
    run_en = en; wd_detect = det;
    f = en && ((m_pl & MASK) == MASK);
    it.pc = m_pc; it.stb = f; it.cnt = m_cnt;
    it.tag = f ? {m_tag, " R4"} : (en ? m_tag : {m_tag, " R2"});
    sb_q.push_back(it);
    rise = det && !m_prev;
    m_tag = !en ? "R2" : (f ? "R5 R6" : "R3");
    if (rise && m_armed) m_tag = {m_tag, (&m_cnt) ? " R9" : " R7"};
    else if (rise || det) m_tag = {m_tag, " R8"};
    if (rise && m_armed && !(&m_cnt)) m_cnt = m_cnt + 1'b1;
    m_armed = f || (m_armed && !rise);
    m_prev = det;
    if (en) begin
      m_pc = f ? m_dl : m_pc + 1'b1;
      m_dl = pn(m_dl);
      m_pl = pn(m_pl);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #2;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_run++;
        if (pc_out !== it.pc || inject_strobe !== it.stb || catch_count !== it.cnt) begin
          n_fail++;
          $display("FAIL %s: pc=%0h stb=%0b cnt=%0d expected pc=%0h stb=%0b cnt=%0d",
                   it.tag, pc_out, inject_strobe, catch_count, it.pc, it.stb, it.cnt);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (pc_out !== 0 || catch_count !== 0 || inject_strobe !== 0) begin
      n_fail++;
      $display("FAIL R1: pc=%0h cnt=%0d stb=%0b expected 0 0 0", pc_out, catch_count, inject_strobe);
    end
    rst_n = 1;
    for (int i = 0; i < 4; i++) step(0, 0);
    for (int i = 0; i < 40; i++) step(1, 0);
    for (int i = 0; i < 400; i++) step(1, (i % 5 == 2) || (i % 5 == 3));
    for (int i = 0; i < 6; i++) step(0, i[1]);
    for (int i = 0; i < 300; i++) step(1, (i % 7 == 1));
    step(1, 0);
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule